// File: doc/BRIEF.md
# UART Transmitter with Stick Parity

This block is the transmit half of an asynchronous serial port. Software writes bytes into a four-entry queue through a small register port, and the block serialises each byte onto a single line. The frame is configurable: 5 to 8 data bits, an optional parity bit, and one or two stop bits. The parity bit can carry even or odd parity of the data bits, or it can be pinned to a constant 1 or 0 (stick parity). A break control drives the line low once the character in flight has completed.

Bit timing comes from a fractional baud generator. It produces a 16x oversampling tick whose average period is an integer plus a fraction in 1/64 steps, counted in clock cycles. The divisor and the line-control registers are written into staging copies. A write to the line-control register arms all three staged values, and they move into the working copies only while no frame is in flight. So software writes the divisors first and the line-control register last, and a character is never reshaped halfway through.

Top module: `uart_tx_core`

## Requirements
- R1: A frame has a start bit (0), then the data bits LSB first, then the optional parity bit, then the stop bits (1). Each bit lasts 16 baud ticks and the idle line is 1. Data length is set by line-control bits [5:4]: 00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8, and the unused upper data bits are dropped.
- R2: With parity enable (line-control bit 1) at 0, no parity bit is sent, whatever the even-select bit (bit 2) and the stick bit (bit 6) hold.
- R3: Parity enable 1, even-select 1 and stick 0 send a parity bit that makes the count of ones over data plus parity even.
- R4: Parity enable 1, even-select 0 and stick 0 send a parity bit that makes that count odd.
- R5: Parity enable 1 with stick 1 sends a constant parity bit: 1 when even-select is 0, and 0 when even-select is 1.
- R6: Line-control bit 3 set sends two stop bits, and clear sends one.
- R7: With the break bit (line-control bit 0) set, the line is driven 0 once the current character has finished, and it stays 0 while the bit stays set.
- R8: While break holds, no queued byte is consumed. After break is cleared, the queued bytes go out intact and in write order.
- R9: Writes to the integer divisor (address 1) and fractional divisor (address 2) do not change the bit rate until the line-control register (address 3) is next written.
- R10: The oversampling tick has an average period of I + F/64 clock cycles (integer I at least 1, F in 0..63), so a bit lasts 16*(I + F/64) cycles.
- R11: `busy` rises with the start bit and falls when the last stop bit ends, so it is high for exactly the frame's bit count times 16 ticks.
- R12: A line-control or divisor change written during a frame takes effect only after that frame has ended.
- R13: A write to the data register (address 0) pushes into a 4-entry queue. `fifo_full` is 1 when the queue holds 4 bytes, and a write while full is dropped.
- R14: After reset the line is 1, `busy` and `fifo_full` are 0, and the configuration is 8 data bits, no parity, one stop bit, with divisor 1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 integer divisor, 2 fractional divisor, 3 line control |
| wr_data | input | 16 | Write data |
| txd | output | 1 | Serial output |
| busy | output | 1 | High while a frame is on the line |
| fifo_full | output | 1 | Transmit queue holds 4 bytes |

## Verification
The bench covers all four stick-parity and even/odd combinations, and it also covers enable-off with the even and stick bits set. A design that decoded the truth table wrongly would send the inverted bit, or would send a parity bit that inflates the measured frame length. It raises break in the middle of a character: a design that cut the frame short, or that consumed the queue during break, would show a truncated frame or missing bytes when transmission resumes. It also writes a divisor without touching line control and changes line control mid-frame. If the divisor leaked early, or the configuration was applied mid-character, the busy-window length and the parity of the next frame would be wrong. A full queue is tested with a fifth write, which a wrong design would send as a fifth frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic       sps;    // [6] constant parity bit select
    logic [1:0] wlen;   // [5:4] data length minus 5
    logic       stp2;   // [3] two stop bits
    logic       eps;    // [2] even parity select
    logic       pen;    // [1] parity enable
    logic       brk;    // [0] hold line low
  } lcr_t;

  localparam int LCR_W = $bits(lcr_t);

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_IDIV = 2'd1;
  localparam logic [1:0] ADDR_FDIV = 2'd2;
  localparam logic [1:0] ADDR_LCR  = 2'd3;

  localparam lcr_t LCR_RESET = '{sps: 1'b0, wlen: 2'b11, stp2: 1'b0,
                                 eps: 1'b0, pen: 1'b0, brk: 1'b0};

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = cnt;
    if (do_push) wr_ptr_nx = wr_ptr + AW'(1);
    if (do_pop)  rd_ptr_nx = rd_ptr + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_nx = cnt + CW'(1);
      2'b01:   cnt_nx = cnt - CW'(1);
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int IDIV_W = 16,
  parameter int FDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [IDIV_W-1:0] idiv,
  input  logic [FDIV_W-1:0] fdiv,
  output logic              tick
);
  localparam int ACC_W = IDIV_W + FDIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FDIV_W;

  logic [ACC_W-1:0] acc, acc_nx, sum, div_full, div_eff;
  logic             tick_nx;

  always_comb begin
    div_full = {1'b0, idiv, fdiv};
    div_eff  = (div_full < STEP) ? STEP : div_full;
    sum      = acc + STEP;
    tick_nx  = (sum >= div_eff);
    if (restart)      acc_nx = '0;
    else if (tick_nx) acc_nx = sum - div_eff;
    else              acc_nx = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_nx;
      tick <= tick_nx && !restart;
    end
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  lcr_t              cfg,
  output logic              busy,
  output logic              bit_out
);
  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);
  localparam int TW = $clog2(OVS);

  logic [FW-1:0]     shreg, shreg_nx, vec;
  logic [CW-1:0]     left, left_nx, wl, nbits;
  logic [TW-1:0]     tcnt, tcnt_nx;
  logic              busy_nx;
  logic [DATA_W-1:0] dmask;
  logic              par_bit;

  // frame image built from the byte and the active line control
  always_comb begin
    wl    = CW'(cfg.wlen) + CW'(5);
    dmask = data & ~({DATA_W{1'b1}} << wl);
    if (cfg.sps)      par_bit = ~cfg.eps;
    else if (cfg.eps) par_bit = ^dmask;
    else              par_bit = ~^dmask;
    vec = ({{(FW-DATA_W){1'b0}}, dmask} << 1) | ({FW{1'b1}} << (wl + CW'(1)));
    if (cfg.pen && !par_bit) vec = vec & ~(FW'(1) << (wl + CW'(1)));
    nbits = CW'(2) + wl + CW'(cfg.pen) + CW'(cfg.stp2);
  end

  always_comb begin
    shreg_nx = shreg;
    left_nx  = left;
    tcnt_nx  = tcnt;
    busy_nx  = busy;
    if (!busy) begin
      if (load) begin
        shreg_nx = vec;
        left_nx  = nbits;
        tcnt_nx  = '0;
        busy_nx  = 1'b1;
      end
    end else if (tick) begin
      if (tcnt == TW'(OVS - 1)) begin
        tcnt_nx  = '0;
        shreg_nx = {1'b1, shreg[FW-1:1]};
        left_nx  = left - CW'(1);
        if (left == CW'(1)) busy_nx = 1'b0;
      end else begin
        tcnt_nx = tcnt + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
      busy  <= 1'b0;
    end else begin
      shreg <= shreg_nx;
      left  <= left_nx;
      tcnt  <= tcnt_nx;
      busy  <= busy_nx;
    end
  end

  assign bit_out = shreg[0];

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int IDIV_W     = 16,
  parameter int FDIV_W     = 6,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [IDIV_W-1:0] wr_data,
  output logic              txd,
  output logic              busy,
  output logic              fifo_full
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [IDIV_W-1:0] idiv_stg, idiv_act, idiv_stg_nx, idiv_act_nx;
  logic [FDIV_W-1:0] fdiv_stg, fdiv_act, fdiv_stg_nx, fdiv_act_nx;
  lcr_t              lcr_stg, lcr_act, lcr_stg_nx, lcr_act_nx;
  logic              pend, pend_nx, apply;
  logic              fifo_push, fifo_pop, fifo_empty;
  logic [DATA_W-1:0] fifo_dout;
  logic              baud_tick, frame_bit;

  assign apply = pend && !busy;

  always_comb begin
    idiv_stg_nx = idiv_stg;
    fdiv_stg_nx = fdiv_stg;
    lcr_stg_nx  = lcr_stg;
    idiv_act_nx = idiv_act;
    fdiv_act_nx = fdiv_act;
    lcr_act_nx  = lcr_act;
    pend_nx     = pend;
    if (apply) begin
      idiv_act_nx = idiv_stg;
      fdiv_act_nx = fdiv_stg;
      lcr_act_nx  = lcr_stg;
      pend_nx     = 1'b0;
    end
    if (wr_en) begin
      case (wr_addr)
        ADDR_IDIV: idiv_stg_nx = wr_data;
        ADDR_FDIV: fdiv_stg_nx = wr_data[FDIV_W-1:0];
        ADDR_LCR: begin
          lcr_stg_nx = lcr_t'(wr_data[LCR_W-1:0]);
          pend_nx    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idiv_stg <= IDIV_W'(1);
      fdiv_stg <= '0;
      lcr_stg  <= LCR_RESET;
      idiv_act <= IDIV_W'(1);
      fdiv_act <= '0;
      lcr_act  <= LCR_RESET;
      pend     <= 1'b0;
    end else begin
      idiv_stg <= idiv_stg_nx;
      fdiv_stg <= fdiv_stg_nx;
      lcr_stg  <= lcr_stg_nx;
      idiv_act <= idiv_act_nx;
      fdiv_act <= fdiv_act_nx;
      lcr_act  <= lcr_act_nx;
      pend     <= pend_nx;
    end
  end

  assign fifo_push = wr_en && (wr_addr == ADDR_DATA);
  assign fifo_pop  = !busy && baud_tick && !fifo_empty && !lcr_act.brk && !pend;

  uart_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (fifo_push),
    .din   (wr_data[DATA_W-1:0]),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_tx_baud #(.IDIV_W(IDIV_W), .FDIV_W(FDIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (apply),
    .idiv    (idiv_act),
    .fdiv    (fdiv_act),
    .tick    (baud_tick)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (baud_tick),
    .load    (fifo_pop),
    .data    (fifo_dout),
    .cfg     (lcr_act),
    .busy    (busy),
    .bit_out (frame_bit)
  );

  assign txd = busy ? frame_bit : !lcr_act.brk;

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int IDIV_W = 16,
  parameter int FDIV_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              busy,
  input logic              fifo_full,
  input logic              fifo_pop,
  input logic [6:0]        lcr_act,
  input logic [IDIV_W-1:0] idiv_act,
  input logic [FDIV_W-1:0] fdiv_act
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lcr_act[0]) |-> txd); // R1

  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && lcr_act[0]) |-> !txd); // R7

  AST_BRK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_act[0] |-> !fifo_pop); // R8

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R11

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lcr_act) && $stable(idiv_act) && $stable(fdiv_act))); // R12

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !fifo_pop) |=> fifo_full); // R13

endmodule

bind uart_tx_core uart_tx_checker #(.IDIV_W(IDIV_W), .FDIV_W(FDIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .txd       (txd),
  .busy      (busy),
  .fifo_full (fifo_full),
  .fifo_pop  (fifo_pop),
  .lcr_act   (lcr_act),
  .idiv_act  (idiv_act),
  .fdiv_act  (fdiv_act)
);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        txd, busy, fifo_full;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  uart_tx_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .txd(txd), .busy(busy), .fifo_full(fifo_full)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {line control[6:0], data[7:0]}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {7'h30, 8'hA5},  // 8 bits, no parity
    {7'h36, 8'h5B},  // 8 bits, even
    {7'h32, 8'h5B},  // 8 bits, odd
    {7'h72, 8'h00},  // stick, constant 1
    {7'h76, 8'hFF},  // stick, constant 0
    {7'h00, 8'hFF},  // 5 bits, no parity
    {7'h2A, 8'h80},  // 7 bits, odd, 2 stop
    {7'h16, 8'h2D},  // 6 bits, even
    {7'h74, 8'h3C},  // parity off with even and stick set
    {7'h3E, 8'h01}   // 8 bits, even, 2 stop
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called at a negedge; counts negedges with busy high, samples bit centres
  task automatic capture(input int bitclk, output logic [15:0] bits, output int len);
    int cnt;
    bits = '1;
    while (!busy) @(negedge clk);
    cnt = 0;
    while (busy) begin
      if ((cnt % bitclk) == (bitclk / 2) && (cnt / bitclk) < 16) bits[cnt / bitclk] = txd;
      cnt++;
      @(negedge clk);
    end
    len = cnt;
  endtask

  task automatic check_frame(input logic [6:0] lcr, input logic [7:0] data,
                             input int bitclk, input logic [15:0] bits, input int len);
    int wl, pen, eps, stp2, sps, nb, ones, pidx;
    logic [7:0] expd, gotd;
    logic       exp_par;
    wl = int'(lcr[5:4]) + 5; pen = lcr[1]; eps = lcr[2]; stp2 = lcr[3]; sps = lcr[6];
    expd = 8'h00; gotd = 8'h00;
    for (int i = 0; i < wl; i++) begin
      expd[i] = data[i];
      gotd[i] = bits[i + 1];
    end
    nb = 2 + wl + pen + stp2;
    chk(bits[0] == 1'b0, "R1 start bit", int'(bits[0]), 0);
    chk(gotd == expd, "R1 data bits", int'(gotd), int'(expd));
    pidx = 1 + wl;
    if (pen != 0) begin
      ones = $countones(expd);
      if (sps != 0)      exp_par = (eps == 0);
      else if (eps != 0) exp_par = ones[0];
      else               exp_par = !ones[0];
      if (sps != 0)      chk(bits[pidx] == exp_par, "R5 stick parity", int'(bits[pidx]), int'(exp_par));
      else if (eps != 0) chk(bits[pidx] == exp_par, "R3 even parity", int'(bits[pidx]), int'(exp_par));
      else               chk(bits[pidx] == exp_par, "R4 odd parity", int'(bits[pidx]), int'(exp_par));
      pidx++;
    end
    chk(bits[pidx] == 1'b1, "R1 stop bit", int'(bits[pidx]), 1);
    if (stp2 != 0) chk(bits[pidx + 1] == 1'b1, "R6 second stop bit", int'(bits[pidx + 1]), 1);
    chk(len >= nb * bitclk - 2 && len <= nb * bitclk + 2, "R11 busy window", len, nb * bitclk);
    if (pen == 0) chk(len >= nb * bitclk - 2 && len <= nb * bitclk + 2, "R2 no parity bit", len, nb * bitclk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic [15:0] bits;
  int          len;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(txd == 1'b1, "R14 reset line", int'(txd), 1);
    chk(busy == 1'b0, "R14 reset busy", int'(busy), 0);
    chk(fifo_full == 1'b0, "R14 reset fifo_full", int'(fifo_full), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14: default configuration 8N1 at divisor 1.0
    wr(2'd0, 16'h00C3);
    capture(16, bits, len);
    check_frame(7'h30, 8'hC3, 16, bits, len);

    // table of frame formats
    for (int v = 0; v < NV; v++) begin
      wr(2'd3, {9'd0, VEC[v][14:8]});
      wr(2'd0, {8'd0, VEC[v][7:0]});
      capture(16, bits, len);
      check_frame(VEC[v][14:8], VEC[v][7:0], 16, bits, len);
    end

    // R9: divisor write alone has no effect
    wr(2'd3, 16'h0030);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0055);
    capture(16, bits, len);
    chk(len == 160, "R9 staged divisor not yet used", len, 160);
    wr(2'd3, 16'h0030);
    wr(2'd0, 16'h0055);
    capture(32, bits, len);
    chk(len >= 318 && len <= 322, "R9 divisor applied by line-control write", len, 320);
    check_frame(7'h30, 8'h55, 32, bits, len);

    // R10: fractional divisor 1 + 32/64
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd32);
    wr(2'd3, 16'h0030);
    wr(2'd0, 16'h00B4);
    capture(24, bits, len);
    chk(len >= 238 && len <= 242, "R10 fractional bit time", len, 240);
    check_frame(7'h30, 8'hB4, 24, bits, len);
    wr(2'd2, 16'd0);
    wr(2'd3, 16'h0030);

    // R12: line control written mid-frame applies to the next frame only
    wr(2'd0, 16'h0011);
    fork
      capture(16, bits, len);
      begin
        wr(2'd0, 16'h0022);
        repeat (40) @(negedge clk);
        wr(2'd3, 16'h0036);
      end
    join
    chk(len == 160, "R12 current frame unchanged", len, 160);
    check_frame(7'h30, 8'h11, 16, bits, len);
    capture(16, bits, len);
    chk(len == 176, "R12 next frame uses new format", len, 176);
    check_frame(7'h36, 8'h22, 16, bits, len);

    // R7: break raised mid-frame; frame completes then line held low
    wr(2'd3, 16'h0030);
    wr(2'd0, 16'h0096);
    fork
      capture(16, bits, len);
      begin
        repeat (40) @(negedge clk);
        wr(2'd3, 16'h0031);
      end
    join
    check_frame(7'h30, 8'h96, 16, bits, len);
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R7 line low after frame", int'(txd), 0);

    // R8/R13: queue fills under break, nothing consumed
    for (int i = 1; i <= 4; i++) wr(2'd0, 16'(i));
    chk(fifo_full == 1'b1, "R13 full after four writes", int'(fifo_full), 1);
    repeat (300) @(negedge clk);
    chk(txd == 1'b0, "R7 line held low", int'(txd), 0);
    chk(busy == 1'b0, "R8 no frame during break", int'(busy), 0);
    chk(fifo_full == 1'b1, "R8 queue untouched during break", int'(fifo_full), 1);
    wr(2'd0, 16'h00EE);
    wr(2'd3, 16'h0030);
    for (int i = 1; i <= 4; i++) begin
      capture(16, bits, len);
      check_frame(7'h30, 8'(i), 16, bits, len);
      chk(bits[8:1] == 8'(i), "R8 resumed in order", int'(bits[8:1]), i);
    end
    repeat (300) @(negedge clk);
    chk(busy == 1'b0, "R13 write while full dropped", int'(busy), 0);
    chk(fifo_full == 1'b0, "R13 queue drained", int'(fifo_full), 0);
    chk(txd == 1'b1, "R1 idle high", int'(txd), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule